// File: doc/BRIEF.md
# Two-Rail Power Sequencing Controller

This block drives the enables of two switching converter rails, a core rail and a main rail, in a fixed order while they come up and the mirror of that order while they go down. A strap input chooses which rail leads. Each rail has a second strap that picks one of two default output voltages. The block reports these voltages as codes for the converters to use. A power request starts and ends a sequence. A power-good input from each rail moves the sequence forward. A timeout covers the case where the leading rail never reports good. On power-down, a delay covers the case where the trailing rail's power-good never drops.

A battery-cover input gives early warning that the battery is about to be removed. When it goes low, both rails are switched off at once and a low-power flag for the linear regulators is raised. Straps are sampled only when a power-up begins. The sequencing state is reported on a two-bit status output.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset, both enables are 0, status is 0, fault is 0, ldo_lp is 0, core_code is 150 and main_code is 300.
- R2: With order_sel=0 at power-up start, core_en rises one cycle after pwr_req is seen. main_en rises one cycle after core_pg is seen high. On power-down, main_en falls first and core_en falls one cycle after main_pg is seen low.
- R3: With order_sel=1 at power-up start, the same sequence runs with the roles swapped: main leads on the way up and is the last rail off on the way down.
- R4: core_code is 150 when core_vsel was 0 at power-up start and 160 when it was 1. Codes are in 10 mV units.
- R5: main_code is 300 when main_vsel was 0 at power-up start and 330 when it was 1.
- R6: order_sel, core_vsel and main_vsel are sampled only on the OFF-to-first-up transition. Changes to them at any other time have no effect on the codes or on the order.
- R7: If the leading rail's power-good is not seen within UP_TIMEOUT (default 16) cycles in first-up, the trailing rail is enabled anyway and fault goes to 1. fault returns to 0 at the next power-up start.
- R8: In first-down, if the trailing rail's power-good stays high, the leading rail is switched off after DOWN_DELAY (default 8) cycles.
- R9: While cover_n is 0, the next clock edge forces status to 0, forces both enables to 0 and sets ldo_lp to 1. pwr_req is ignored while cover_n is 0. ldo_lp is cleared at the next power-up start.
- R10: status encodes the sequence state as 0=off, 1=first rail up, 2=both up, 3=first rail down. Both enables are 0 in state 0. Exactly one enable is 1 in states 1 and 3.
- R11: If pwr_req drops during first-up, the leading rail is switched off at the next edge and status returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req | input | 1 | Request to power the rails |
| order_sel | input | 1 | Order strap: 0 core leads, 1 main leads |
| core_vsel | input | 1 | Core default voltage strap |
| main_vsel | input | 1 | Main default voltage strap |
| core_pg | input | 1 | Core rail power-good |
| main_pg | input | 1 | Main rail power-good |
| cover_n | input | 1 | Battery cover present, low means removal pending |
| core_en | output | 1 | Core rail enable |
| main_en | output | 1 | Main rail enable |
| core_code | output | 9 | Core voltage code, 10 mV units |
| main_code | output | 9 | Main voltage code, 10 mV units |
| ldo_lp | output | 1 | Linear regulators low-power flag |
| fault | output | 1 | Leading rail power-up timed out |
| status | output | 2 | Sequencing state |

## Verification
The hardest case to reach is a battery-cover drop that lands in a particular sequencing state. The first-down window in particular lasts only until the trailing power-good falls. The stimulus holds power-good high through directed down-sequences and pulls cover_n low inside them. The random phase drops cover_n and pwr_req in short bursts, with power-good following the enables after a random lag, so that every state meets every abort. The timeout path is reached only by holding the leading power-good low for the full window.

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl #(
  parameter int UP_TIMEOUT = 16,
  parameter int DOWN_DELAY = 8,
  parameter int CODE_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_req,
  input  logic              order_sel,
  input  logic              core_vsel,
  input  logic              main_vsel,
  input  logic              core_pg,
  input  logic              main_pg,
  input  logic              cover_n,
  output logic              core_en,
  output logic              main_en,
  output logic [CODE_W-1:0] core_code,
  output logic [CODE_W-1:0] main_code,
  output logic              ldo_lp,
  output logic              fault,
  output logic [1:0]        status
);
  localparam int MAXC = (UP_TIMEOUT > DOWN_DELAY) ? UP_TIMEOUT : DOWN_DELAY;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] UP_LAST = CW'(UP_TIMEOUT - 1);
  localparam logic [CW-1:0] DN_LAST = CW'(DOWN_DELAY - 1);
  localparam logic [CODE_W-1:0] CORE_LO = CODE_W'(150);
  localparam logic [CODE_W-1:0] CORE_HI = CODE_W'(160);
  localparam logic [CODE_W-1:0] MAIN_LO = CODE_W'(300);
  localparam logic [CODE_W-1:0] MAIN_HI = CODE_W'(330);

  typedef enum logic [1:0] {S_OFF = 2'd0, S_UP = 2'd1, S_BOTH = 2'd2, S_DOWN = 2'd3} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        ord_q, cv_q, mv_q;

  wire lead_pg  = ord_q ? main_pg : core_pg;
  wire trail_pg = ord_q ? core_pg : main_pg;
  wire one_on   = (st == S_UP) || (st == S_DOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      cnt    <= '0;
      ord_q  <= 1'b0;
      cv_q   <= 1'b0;
      mv_q   <= 1'b0;
      ldo_lp <= 1'b0;
      fault  <= 1'b0;
    end else if (!cover_n) begin
      st     <= S_OFF;
      cnt    <= '0;
      ldo_lp <= 1'b1;
    end else begin
      case (st)
        S_OFF: if (pwr_req) begin
          st     <= S_UP;
          cnt    <= '0;
          ord_q  <= order_sel;
          cv_q   <= core_vsel;
          mv_q   <= main_vsel;
          ldo_lp <= 1'b0;
          fault  <= 1'b0;
        end
        S_UP: begin
          if (!pwr_req) begin
            st  <= S_OFF;
            cnt <= '0;
          end else if (lead_pg) begin
            st  <= S_BOTH;
            cnt <= '0;
          end else if (cnt == UP_LAST) begin
            st    <= S_BOTH;
            cnt   <= '0;
            fault <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BOTH: if (!pwr_req) begin
          st  <= S_DOWN;
          cnt <= '0;
        end
        default: begin
          if (!trail_pg || cnt == DN_LAST) begin
            st  <= S_OFF;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign core_en   = one_on ? ~ord_q : (st == S_BOTH);
  assign main_en   = one_on ?  ord_q : (st == S_BOTH);
  assign core_code = cv_q ? CORE_HI : CORE_LO;
  assign main_code = mv_q ? MAIN_HI : MAIN_LO;
  assign status    = st;
endmodule

// File: rtl/rail_seq_ctrl_chk.sv
module rail_seq_ctrl_chk #(
  parameter int CODE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cover_n,
  input logic              core_en,
  input logic              main_en,
  input logic [CODE_W-1:0] core_code,
  input logic [CODE_W-1:0] main_code,
  input logic              ldo_lp,
  input logic              fault,
  input logic [1:0]        status
);
  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd0 |-> !core_en && !main_en);
  // R10
  single_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1 || status == 2'd3) |-> $countones({core_en, main_en}) == 1);
  // R9
  cover_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cover_n |=> !core_en && !main_en && ldo_lp && status == 2'd0);
  // R7
  fault_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> status == 2'd2);
  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'd0 && $past(status) != 2'd0) |-> $stable(core_code) && $stable(main_code));
endmodule

bind rail_seq_ctrl rail_seq_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cover_n(cover_n), .core_en(core_en), .main_en(main_en),
  .core_code(core_code), .main_code(main_code), .ldo_lp(ldo_lp), .fault(fault),
  .status(status)
);

// File: tb/sim_rail_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rail_seq_ctrl;
  localparam int T_UP = 16;
  localparam int T_DN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_req = 0, order_sel = 0, core_vsel = 0, main_vsel = 0;
  logic core_pg = 0, main_pg = 0, cover_n = 1;
  logic core_en, main_en, ldo_lp, fault;
  logic [8:0] core_code, main_code;
  logic [1:0] status;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rail_seq_ctrl u0 (.*);

  int m_st = 0, m_cnt = 0;
  bit m_ord = 0, m_cv = 0, m_mv = 0, m_lp = 0, m_fault = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ord = 0; m_cv = 0; m_mv = 0; m_lp = 0; m_fault = 0;
    end else if (!cover_n) begin
      m_st = 0; m_cnt = 0; m_lp = 1;
    end else begin
      case (m_st)
        0: if (pwr_req) begin
             m_st = 1; m_cnt = 0; m_ord = order_sel; m_cv = core_vsel; m_mv = main_vsel;
             m_lp = 0; m_fault = 0;
           end
        1: if (!pwr_req) begin m_st = 0; m_cnt = 0; end
           else if (m_ord ? main_pg : core_pg) begin m_st = 2; m_cnt = 0; end
           else if (m_cnt == T_UP - 1) begin m_st = 2; m_cnt = 0; m_fault = 1; end
           else m_cnt++;
        2: if (!pwr_req) begin m_st = 3; m_cnt = 0; end
        default: if (!(m_ord ? core_pg : main_pg) || m_cnt == T_DN - 1) begin m_st = 0; m_cnt = 0; end
                 else m_cnt++;
      endcase
    end
  end

  function automatic bit exp_core_en();
    return (m_st == 2) || ((m_st == 1 || m_st == 3) && !m_ord);
  endfunction
  function automatic bit exp_main_en();
    return (m_st == 2) || ((m_st == 1 || m_st == 3) && m_ord);
  endfunction
  function automatic int exp_core_code();
    return m_cv ? 160 : 150;
  endfunction
  function automatic int exp_main_code();
    return m_mv ? 330 : 300;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp(input string tag);
    chk(core_en == exp_core_en(), tag, "core_en", core_en, exp_core_en());
    chk(main_en == exp_main_en(), tag, "main_en", main_en, exp_main_en());
    chk(status == 2'(m_st), tag, "status", status, m_st);
    chk(int'(core_code) == exp_core_code(), tag, "core_code", core_code, exp_core_code());
    chk(int'(main_code) == exp_main_code(), tag, "main_code", main_code, exp_main_code());
    chk(ldo_lp == m_lp, tag, "ldo_lp", ldo_lp, m_lp);
    chk(fault == m_fault, tag, "fault", fault, m_fault);
  endtask

  task automatic tick(input string tag);
    @(posedge clk); #1; cmp(tag); @(negedge clk);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(core_en == 0 && main_en == 0 && status == 0, "R1", "rails/status", {core_en, main_en, status}, 0);
    chk(core_code == 150 && main_code == 300, "R1", "codes", core_code, 150);
    chk(ldo_lp == 0 && fault == 0, "R1", "flags", {ldo_lp, fault}, 0);
    rst_n = 1;
    tick("R1");

    // R2 core leads, R4/R5 high straps
    order_sel = 0; core_vsel = 1; main_vsel = 1; pwr_req = 1;
    tick("R2");
    chk(core_en && !main_en, "R2", "core first", {core_en, main_en}, 2);
    chk(core_code == 160, "R4", "core_code high", core_code, 160);
    chk(main_code == 330, "R5", "main_code high", main_code, 330);
    // R6 strap changes while on ignored
    order_sel = 1; core_vsel = 0; main_vsel = 0;
    ticks(3, "R6");
    core_pg = 1; tick("R2");
    chk(status == 2 && main_en, "R2", "both up", status, 2);
    main_pg = 1; ticks(2, "R6");
    chk(core_code == 160 && main_code == 330, "R6", "codes held", core_code, 160);
    pwr_req = 0; tick("R2");
    chk(core_en && !main_en && status == 3, "R2", "main off first", {core_en, main_en}, 2);
    ticks(2, "R2");
    main_pg = 0; tick("R2");
    chk(!core_en && status == 0, "R2", "core off last", core_en, 0);
    core_pg = 0; tick("R2");

    // R3 main leads, R4/R5 low straps, R8 down delay
    order_sel = 1; core_vsel = 0; main_vsel = 0; pwr_req = 1;
    tick("R3");
    chk(main_en && !core_en, "R3", "main first", {core_en, main_en}, 1);
    chk(core_code == 150, "R4", "core_code low", core_code, 150);
    chk(main_code == 300, "R5", "main_code low", main_code, 300);
    main_pg = 1; tick("R3");
    core_pg = 1; ticks(2, "R3");
    pwr_req = 0; tick("R3");
    chk(main_en && !core_en, "R3", "core off first", {core_en, main_en}, 1);
    ticks(T_DN - 1, "R8");
    chk(status == 3, "R8", "still down", status, 3);
    tick("R8");
    chk(status == 0 && !main_en, "R8", "delay expiry", status, 0);
    core_pg = 0; main_pg = 0; tick("R8");

    // R7 timeout then fault clear
    order_sel = 0; pwr_req = 1;
    ticks(T_UP, "R7");
    chk(status == 1, "R7", "before timeout", status, 1);
    tick("R7");
    chk(status == 2 && fault, "R7", "timeout fault", fault, 1);
    pwr_req = 0; tick("R7");
    ticks(T_DN, "R7");
    pwr_req = 1; tick("R7");
    chk(!fault, "R7", "fault cleared", fault, 0);

    // R11 request drop during first-up
    pwr_req = 0; tick("R11");
    chk(status == 0 && !core_en, "R11", "abort up", status, 0);

    // R9 cover drop during first-down
    pwr_req = 1; tick("R9"); core_pg = 1; tick("R9"); main_pg = 1; tick("R9");
    pwr_req = 0; tick("R9");
    cover_n = 0; tick("R9");
    chk(!core_en && !main_en && ldo_lp && status == 0, "R9", "forced off", {core_en, main_en, ldo_lp}, 1);
    pwr_req = 1; ticks(3, "R9");
    chk(status == 0 && ldo_lp, "R9", "req ignored", status, 0);
    core_pg = 0; main_pg = 0;
    cover_n = 1; tick("R9");
    chk(status == 1 && !ldo_lp, "R9", "lp cleared", ldo_lp, 0);
    // R10 encoding through cover drop in both-up
    core_pg = 1; tick("R10");
    chk(status == 2, "R10", "both code", status, 2);
    cover_n = 0; tick("R10");
    cover_n = 1; pwr_req = 0; core_pg = 0; tick("R10");

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      pwr_req   = ($urandom % 16) != 0 ? pwr_req : ~pwr_req;
      cover_n   = ($urandom % 60) != 0;
      order_sel = $urandom % 2;
      core_vsel = $urandom % 2;
      main_vsel = $urandom % 2;
      core_pg   = core_en ? (($urandom % 3) != 0) : (($urandom % 10) == 0);
      main_pg   = main_en ? (($urandom % 3) != 0) : (($urandom % 10) == 0);
      tick("RAND");
    end
    finish_run();
  end
endmodule